// File: doc/BRIEF.md
# Skip-Ahead Subset Candidate Generator

This block steps through the non-empty subsets of N features. Each subset is an N-bit tuple. Element a1 is the most significant bit and element aN is the least significant bit. The tuples are visited in ascending binary order, but whole ranges are jumped over when they cannot hold a new minimal covering subset.

The current tuple sits in a register and drives the `candidate` output. An outside evaluator answers in the same cycle with two inputs:
- `isCover`: high when every matrix row shares at least one set bit with the tuple.
- `failRow`: when `isCover` is low, the first row that shares no set bit with the tuple.

On the next clock edge the generator loads a new tuple:
- **Success rule** (the tuple covers): the value of the tuple's lowest set bit is added to the tuple.
- **Failure rule** (the tuple does not cover): the tuple is cut at the lowest set bit of the failing row.

The scan ends when the success rule carries out of the top bit, which means the next tuple would lie beyond the all-ones tuple. At that point `done` rises and everything freezes until reset. Matrix storage and result filtering are not part of this block.

Top module: `subsetStepper`

## Requirements
- R1: One cycle after reset is released, `candidate` holds 0…01 (only bit 0, element aN, set), and `done` is low.
- R2: Bit `candidate[N-1]` is element a1 and bit `candidate[0]` is element aN. "Lowest set bit" means the set bit with the smallest vector index.
- R3: When `enable` is high, `done` is low and `isCover` is high, the next tuple is the current tuple plus the value of its lowest set bit, provided this sum fits in N bits.
- R4: When `enable` is high, `done` is low, `isCover` is low and `failRow` is non-zero, let j be the index of the lowest set bit of `failRow`. The next tuple keeps the current bits above j, has bit j set, and has every bit below j cleared.
- R5: While scanning with a `failRow` that shares no bit with the tuple, every step makes the tuple strictly larger, and the tuple is never zero.
- R6: While `enable` is low, `candidate` and `done` keep their values.
- R7: When the success-rule sum carries out of N bits, `done` rises at that edge and `candidate` keeps the last covering tuple.
- R8: Once `done` is high, it stays high and `candidate` does not change until reset, whatever the other inputs do.
- R9: A failure answer with `failRow` equal to zero ends the scan: `done` rises at that edge and `candidate` keeps its value.
- R10: For N=5 with rows 00100 and 01000 (written a1 first), the visited tuples are 00001, 00100, 01000, 01100, 10000, 10100, 11000, 11100, and then `done` rises. The only covering tuples among them are 01100 and 11100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Lets the scan advance by one step per cycle |
| isCover | input | 1 | Evaluator answer for the present tuple: every row is hit |
| failRow | input | N | First row not hit by the present tuple, read only when `isCover` is low |
| candidate | output | N | Present tuple, a1 in the MSB |
| done | output | 1 | The scan is over; held until reset |

## Verification
Each answer on `isCover`/`failRow` takes effect on `candidate` or `done` exactly one clock edge later, because the only storage on that path is one register each. The bench therefore drives the evaluator answer at the falling edge, using the tuple it sees there, and compares the new tuple at the next falling edge against a step-by-step software model of R3, R4, R7 and R9. Holds under a low `enable` and after `done` are checked over several edges. The reset tuple is checked at the first falling edge after reset is released.

// File: rtl/subset_stepper_pkg.sv
package subset_stepper_pkg;

  typedef struct packed {
    logic advance;  // load the computed next tuple
    logic finish;   // end the scan, freeze everything
  } stepStrobes_t;

  typedef struct packed {
    logic sumCarry;   // success sum left the N-bit range
    logic rowEmpty;   // failing row has no set bit
  } stepStatus_t;

  typedef enum logic [0:0] {
    ST_SCAN     = 1'b0,
    ST_FINISHED = 1'b1
  } stepState_t;

endpackage

// File: rtl/low_bit_finder.sv
module lowBitFinder #(
  parameter int N    = 8,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    vecIn,
  output logic [IDXW-1:0] lowIdx,
  output logic            found
);

  // Scan from the top down so that the lowest set bit is the last one written.
  always_comb begin
    lowIdx = '0;
    found  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vecIn[i]) begin
        lowIdx = IDXW'(i);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/subset_stepper_dp.sv
module subsetStepperDp
  import subset_stepper_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  stepStrobes_t strobes,
  input  logic         isCover,
  input  logic [N-1:0] failRow,
  output stepStatus_t  status,
  output logic [N-1:0] candidate,
  output logic         done
);

  localparam int IDXW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]    candReg;
  logic            doneReg;
  logic [IDXW-1:0] candLowIdx;
  logic            candFound;
  logic [IDXW-1:0] rowLowIdx;
  logic            rowFound;
  logic [N:0]      successSum;
  logic [N-1:0]    failNext;
  logic [N-1:0]    nextCand;

  // Success rule: locate the lowest set bit of the tuple.
  lowBitFinder #(.N(N), .IDXW(IDXW)) u_candFinder (
    .vecIn (candReg),
    .lowIdx(candLowIdx),
    .found (candFound)
  );

  // Failure rule: locate the lowest set bit of the failing row.
  lowBitFinder #(.N(N), .IDXW(IDXW)) u_rowFinder (
    .vecIn (failRow),
    .lowIdx(rowLowIdx),
    .found (rowFound)
  );

  assign successSum = {1'b0, candReg} + ((N+1)'(1) << candLowIdx);

  // Keep the bits above the row's lowest set bit, set that bit, clear the rest.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (i > int'(rowLowIdx))       failNext[i] = candReg[i];
      else if (i == int'(rowLowIdx)) failNext[i] = 1'b1;
      else                           failNext[i] = 1'b0;
    end
  end

  assign nextCand        = isCover ? successSum[N-1:0] : failNext;
  assign status.sumCarry = successSum[N] | ~candFound;
  assign status.rowEmpty = ~rowFound;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candReg <= N'(1);
      doneReg <= 1'b0;
    end else begin
      if (strobes.advance) candReg <= nextCand;
      if (strobes.finish)  doneReg <= 1'b1;
    end
  end

  assign candidate = candReg;
  assign done      = doneReg;

endmodule

// File: rtl/subset_stepper_ctrl.sv
module subsetStepperCtrl
  import subset_stepper_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         isCover,
  input  stepStatus_t  status,
  output stepStrobes_t strobes
);

  stepState_t state;
  stepState_t stateNext;
  logic       endNow;

  // The scan ends on a carry from the success rule,
  // or on a failure answer whose row has no set bit.
  assign endNow = isCover ? status.sumCarry : status.rowEmpty;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    if (state == ST_SCAN && enable) begin
      if (endNow) begin
        strobes.finish = 1'b1;
        stateNext      = ST_FINISHED;
      end else begin
        strobes.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SCAN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/subset_stepper.sv
module subsetStepper
  import subset_stepper_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         isCover,
  input  logic [N-1:0] failRow,
  output logic [N-1:0] candidate,
  output logic         done
);

  stepStrobes_t strobes;
  stepStatus_t  status;

  subsetStepperCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .isCover(isCover),
    .status (status),
    .strobes(strobes)
  );

  subsetStepperDp #(.N(N)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .isCover  (isCover),
    .failRow  (failRow),
    .status   (status),
    .candidate(candidate),
    .done     (done)
  );

endmodule

// File: rtl/subset_stepper_chk.sv
module subsetStepperChk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input logic         isCover,
  input logic [N-1:0] failRow,
  input logic [N-1:0] candidate,
  input logic         done
);

  // R5: the tuple is never empty.
  a_r5_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    candidate != '0);

  // R6: a low enable holds both outputs.
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(candidate) && $stable(done)));

  // R8: done is sticky.
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R8: the tuple is frozen once done.
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(candidate));

  // R3/R7: a success step either grows the tuple or ends the scan.
  a_r3_success_grows: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !done && isCover) |=>
      (done || (candidate > $past(candidate))));

  // R4/R5: a proper failure step strictly grows the tuple.
  a_r4_fail_grows: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !done && !isCover && failRow != '0 && (failRow & candidate) == '0)
      |=> (!done && candidate > $past(candidate)));

  // R9: a failure answer with an empty row ends the scan.
  a_r9_empty_row_ends: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !done && !isCover && failRow == '0) |=>
      (done && $stable(candidate)));

endmodule

bind subsetStepper subsetStepperChk #(.N(N)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .isCover  (isCover),
  .failRow  (failRow),
  .candidate(candidate),
  .done     (done)
);

// File: tb/subset_stepper_tb.sv
module subsetStepper_tb;

  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         isCover = 1'b0;
  logic [N-1:0] failRow = '0;
  logic [N-1:0] candidate;
  logic         done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [N-1:0] rows [4];
  int           rowCount;

  // R10: expected visit order for rows 00100 and 01000.
  localparam logic [N-1:0] EXP_SEQ [8] = '{
    5'b00001, 5'b00100, 5'b01000, 5'b01100,
    5'b10000, 5'b10100, 5'b11000, 5'b11100
  };

  always #2 clk = ~clk;

  subsetStepper #(.N(N)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .isCover  (isCover),
    .failRow  (failRow),
    .candidate(candidate),
    .done     (done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  // Evaluator answer for the present tuple.
  task automatic drive_eval();
    logic         cov = 1'b1;
    logic [N-1:0] v   = '0;
    for (int r = 0; r < rowCount; r++) begin
      if ((rows[r] & candidate) == '0) begin
        if (cov) v = rows[r];
        cov = 1'b0;
      end
    end
    isCover = cov;
    failRow = v;
  endtask

  // Software model of R3, R4, R7 and R9: returns {ends, next}.
  function automatic logic [N:0] model_step(input logic [N-1:0] c, input logic cov,
                                            input logic [N-1:0] v);
    logic [N:0]   sum;
    logic [N-1:0] nxt;
    int           j = -1;
    if (cov) begin
      for (int i = N - 1; i >= 0; i--) if (c[i]) j = i;
      sum = {1'b0, c} + ((N+1)'(1) << j);
      return sum[N] ? {1'b1, c} : {1'b0, sum[N-1:0]};
    end
    for (int i = N - 1; i >= 0; i--) if (v[i]) j = i;
    if (j < 0) return {1'b1, c};
    nxt = c;
    for (int i = 0; i < N; i++) if (i < j) nxt[i] = 1'b0;
    nxt[j] = 1'b1;
    return {1'b0, nxt};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Full scan compared with the model at every step (R3, R4, R7).
  task automatic run_model(input string tag);
    logic [N-1:0] expCand = N'(1);
    logic         expDone = 1'b0;
    logic [N:0]   st;
    do_reset();
    enable = 1'b1;
    for (int s = 0; s < 64 && !expDone; s++) begin
      check({tag, " R3/R4 candidate"}, 32'(candidate), 32'(expCand));
      drive_eval();
      st = model_step(candidate, isCover, failRow);
      expDone = st[N];
      expCand = st[N-1:0];
      @(negedge clk);
    end
    check({tag, " R7 done"}, 32'(done), 32'(expDone));
    check({tag, " R7 last tuple"}, 32'(candidate), 32'(expCand));
  endtask

  initial begin
    // R1: reset state.
    rows[0] = 5'b00100; rows[1] = 5'b01000; rowCount = 2;
    do_reset();
    check("R1 reset candidate", 32'(candidate), 32'(5'b00001));
    check("R1 reset done", 32'(done), 32'd0);

    // R6: enable low holds, even with answers that would move it.
    drive_eval();
    repeat (3) @(negedge clk);
    check("R6 hold candidate", 32'(candidate), 32'(5'b00001));
    check("R6 hold done", 32'(done), 32'd0);

    // R10 / R2: table walk of the worked example.
    enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      check("R10 sequence", 32'(candidate), 32'(EXP_SEQ[i]));
      drive_eval();
      if (i == 3 || i == 7) check("R10 covering tuple", 32'(isCover), 32'd1);
      @(negedge clk);
    end
    check("R7 done after carry", 32'(done), 32'd1);
    check("R7 last tuple kept", 32'(candidate), 32'(5'b11100));

    // R8: frozen after done whatever the inputs.
    isCover = 1'b0; failRow = 5'b10000;
    repeat (2) @(negedge clk);
    isCover = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 done sticky", 32'(done), 32'd1);
    check("R8 candidate frozen", 32'(candidate), 32'(5'b11100));

    // R9: failure with an empty row ends the scan at once.
    do_reset();
    enable = 1'b1; isCover = 1'b0; failRow = '0;
    @(negedge clk);
    check("R9 done on empty row", 32'(done), 32'd1);
    check("R9 candidate kept", 32'(candidate), 32'(5'b00001));

    // R5 / R6: pausing mid-scan keeps the tuple.
    rows[0] = 5'b10010; rows[1] = 5'b01001; rowCount = 2;
    do_reset();
    enable = 1'b1;
    drive_eval();
    @(negedge clk);
    enable = 1'b0;
    drive_eval();
    repeat (2) @(negedge clk);
    check("R6 mid-scan hold", 32'(candidate), 32'(5'b00010));

    // Model-driven scans over several matrices.
    rowCount = 0;
    run_model("empty matrix");
    rows[0] = 5'b11111; rowCount = 1;
    run_model("all-ones row");
    rows[0] = 5'b10001; rows[1] = 5'b01110; rows[2] = 5'b00110; rowCount = 3;
    run_model("three rows");
    rows[0] = 5'b10000; rows[1] = 5'b01000; rows[2] = 5'b00100; rows[3] = 5'b00011;
    rowCount = 4;
    run_model("diagonal rows");

    finishRun();
  end

endmodule